// File: doc/BRIEF.md
# Dual-Path IIR Thermal Set-Point Controller

This block turns a digitised temperature target and a digitised thermistor reading into a target drive current for an inner current loop. Each sample pair arrives with a strobe. The block forms the temperature error. It runs that error through a third-order recursive filter. In parallel, a second-order recursive filter runs on the target sample alone and acts as a feed-forward path. The two filter outputs are added into a control voltage. A fixed offset is then removed and the result is multiplied by a programmable reciprocal gain to give the current target.

All arithmetic is fixed point. Coefficients are signed Q2.14 words written through a small register port. The multiplications share one multiply-accumulate unit, which a step counter drives through a fixed schedule. A result therefore appears a fixed number of cycles after each accepted strobe. The strobe is expected at the thermal-loop rate, which is a whole multiple (typically 6 to 10) of the current-loop period, so the schedule has ample slack.

Top module: `tec_thermal_iir`

## Requirements
- R1: The error sample is the target sample minus the thermistor sample, saturated to the signed 16-bit range.
- R2: Error path: y_e[n] = floor((Σ_{k=0..3} coefficient(k)·e[n-k] − Σ_{j=1..3} coefficient(3+j)·y_e[n-j]) / 2^14), saturated to 16 bits. Coefficient addresses 0..3 hold the error feed-forward taps for lags 0..3, and addresses 4..6 hold the feedback taps for lags 1..3.
- R3: Feed-forward path: y_s[n] = floor((Σ_{k=0..2} coefficient(7+k)·s[n-k] − Σ_{j=1..2} coefficient(9+j)·y_s[n-j]) / 2^14), saturated to 16 bits, where s is the target sample. Addresses 7..9 hold the taps for lags 0..2, and addresses 10..11 hold the feedback taps for lags 1..2.
- R4: The control voltage is v = sat16(y_e + y_s). The output is sat16(floor((v − OFFSET)·coefficient(12) / 2^14)), where OFFSET is a parameter with default 12288.
- R5: Each intermediate value (error, path outputs, control voltage) and the output saturates to the range −32768..32767 and never wraps. The filter histories store the saturated values.
- R6: `tgt_vld` is a one-cycle pulse that rises 15 clock cycles after the edge that accepts a strobe. `tgt` changes only in a cycle where `tgt_vld` is high.
- R7: A strobe that arrives while a computation is in progress is ignored. It produces no extra result and leaves the filter histories untouched.
- R8: Synchronous reset clears all filter histories, all coefficients, `tgt` and `tgt_vld` to zero.
- R9: A coefficient write at addresses 0..12 takes effect for the next accepted strobe. Writes to addresses 13..15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | New sample pair present |
| setpt | input | 16 | Signed temperature target sample |
| therm | input | 16 | Signed thermistor sample |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 4 | Coefficient address |
| cfg_data | input | 16 | Signed Q2.14 coefficient value |
| tgt | output | 16 | Signed target current |
| tgt_vld | output | 1 | Result valid pulse |

## Verification
Each path is isolated in turn:
- A unit error tap with every other tap at zero exposes the error subtraction, the offset and the gain.
- A unit feedback tap turns the error path into an integrator, so a wrong history shift or sign shows up as a wrong ramp.
- A half-weight tap on the target with a half-weight feedback tap checks the second-order path apart from the error path.
- Full-scale opposite inputs drive every saturation point.
- A table of mixed, nonzero coefficients with varied samples then exercises every tap and lag at once, against an independent fixed-point model.
- A strobe injected mid-computation, followed by a lag-one tap, shows whether the history was disturbed.

// File: rtl/tec_thermal_iir.sv
module tec_thermal_iir #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FRAC = 14,
  parameter int ACCW = 40,
  parameter logic signed [DW-1:0] OFFSET = 16'sd12288
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] setpt,
  input  logic signed [DW-1:0] therm,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_addr,
  input  logic signed [CW-1:0] cfg_data,
  output logic signed [DW-1:0] tgt,
  output logic                 tgt_vld
);
  localparam int NCOEF = 13;
  localparam int LAST  = 14;
  localparam logic signed [ACCW-1:0] SMAX = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SMIN = ~SMAX;

  function automatic logic signed [DW-1:0] sat(input logic signed [ACCW-1:0] a);
    if (a > SMAX) return SMAX[DW-1:0];
    else if (a < SMIN) return SMIN[DW-1:0];
    else return a[DW-1:0];
  endfunction

  function automatic logic signed [ACCW-1:0] wide(input logic signed [DW-1:0] x);
    return {{(ACCW-DW){x[DW-1]}}, x};
  endfunction

  logic signed [CW-1:0] coef [NCOEF];
  logic signed [DW-1:0] eh [3];
  logic signed [DW-1:0] yeh [3];
  logic signed [DW-1:0] sh [2];
  logic signed [DW-1:0] ysh [2];
  logic signed [DW-1:0] x_err, x_set, ye, vreg;
  logic signed [ACCW-1:0] acc, acc_nxt, prod_ext;
  logic signed [DW:0] op_x, err_raw, vofs;
  logic signed [CW-1:0] op_c;
  logic signed [DW+CW:0] prod;
  logic neg, busy;
  logic [3:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCOEF; i++) coef[i] <= '0;
    end else if (cfg_we && (cfg_addr < 4'(NCOEF))) begin
      coef[cfg_addr] <= cfg_data;
    end
  end

  assign err_raw = {setpt[DW-1], setpt} - {therm[DW-1], therm};
  assign vofs    = {vreg[DW-1], vreg} - {OFFSET[DW-1], OFFSET};

  always_comb begin
    op_x = '0;
    op_c = '0;
    neg  = 1'b0;
    case (step)
      4'd0:  begin op_x = {x_err[DW-1], x_err};     op_c = coef[0]; end
      4'd1:  begin op_x = {eh[0][DW-1], eh[0]};     op_c = coef[1]; end
      4'd2:  begin op_x = {eh[1][DW-1], eh[1]};     op_c = coef[2]; end
      4'd3:  begin op_x = {eh[2][DW-1], eh[2]};     op_c = coef[3]; end
      4'd4:  begin op_x = {yeh[0][DW-1], yeh[0]};   op_c = coef[4]; neg = 1'b1; end
      4'd5:  begin op_x = {yeh[1][DW-1], yeh[1]};   op_c = coef[5]; neg = 1'b1; end
      4'd6:  begin op_x = {yeh[2][DW-1], yeh[2]};   op_c = coef[6]; neg = 1'b1; end
      4'd8:  begin op_x = {x_set[DW-1], x_set};     op_c = coef[7]; end
      4'd9:  begin op_x = {sh[0][DW-1], sh[0]};     op_c = coef[8]; end
      4'd10: begin op_x = {sh[1][DW-1], sh[1]};     op_c = coef[9]; end
      4'd11: begin op_x = {ysh[0][DW-1], ysh[0]};   op_c = coef[10]; neg = 1'b1; end
      4'd12: begin op_x = {ysh[1][DW-1], ysh[1]};   op_c = coef[11]; neg = 1'b1; end
      4'd14: begin op_x = vofs;                     op_c = coef[12]; end
      default: ;
    endcase
  end

  assign prod     = op_x * op_c;
  assign prod_ext = {{(ACCW-DW-CW-1){prod[DW+CW]}}, prod};
  assign acc_nxt  = neg ? acc - prod_ext : acc + prod_ext;

  logic signed [DW-1:0] path_out;
  assign path_out = sat(acc_nxt >>> FRAC);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      step    <= '0;
      acc     <= '0;
      x_err   <= '0;
      x_set   <= '0;
      ye      <= '0;
      vreg    <= '0;
      tgt     <= '0;
      tgt_vld <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        eh[i]  <= '0;
        yeh[i] <= '0;
      end
      for (int i = 0; i < 2; i++) begin
        sh[i]  <= '0;
        ysh[i] <= '0;
      end
    end else begin
      tgt_vld <= 1'b0;
      if (!busy) begin
        if (smp_stb) begin
          busy  <= 1'b1;
          step  <= '0;
          acc   <= '0;
          x_set <= setpt;
          x_err <= sat({{(ACCW-DW-1){err_raw[DW]}}, err_raw});
        end
      end else begin
        step <= step + 4'd1;
        acc  <= acc_nxt;
        case (step)
          4'd7: begin
            ye  <= path_out;
            acc <= '0;
          end
          4'd13: begin
            vreg   <= sat(wide(ye) + wide(path_out));
            acc    <= '0;
            eh[0]  <= x_err;
            eh[1]  <= eh[0];
            eh[2]  <= eh[1];
            yeh[0] <= ye;
            yeh[1] <= yeh[0];
            yeh[2] <= yeh[1];
            sh[0]  <= x_set;
            sh[1]  <= sh[0];
            ysh[0] <= path_out;
            ysh[1] <= ysh[0];
          end
          4'(LAST): begin
            tgt     <= path_out;
            tgt_vld <= 1'b1;
            busy    <= 1'b0;
            step    <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tec_thermal_iir_chk.sv
module tec_thermal_iir_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_stb,
  input logic                 busy,
  input logic signed [DW-1:0] tgt,
  input logic                 tgt_vld
);
  localparam int LAT = 15;
  logic [4:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (smp_stb && !busy) cnt <= 5'd1;
    else if (busy) cnt <= cnt + 5'd1;
    else cnt <= '0;
  end

  // R6: the pulse lasts one cycle
  a_r6_vld_single: assert property (@(posedge clk) disable iff (rst) tgt_vld |=> !tgt_vld);
  // R6: the result comes a fixed time after the accepting edge; cnt is LAT+1 when sampled
  a_r6_latency: assert property (@(posedge clk) disable iff (rst) tgt_vld |-> cnt == 5'(LAT + 1));
  // R6: the output is held between results
  a_r6_tgt_hold: assert property (@(posedge clk) disable iff (rst) !$stable(tgt) |-> tgt_vld);
  // R7: a strobe while busy cannot extend or restart the computation
  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (rst) busy |-> cnt <= 5'(LAT));
  // R8: state out of reset
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (tgt == '0 && !tgt_vld));
endmodule

bind tec_thermal_iir tec_thermal_iir_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .busy(busy), .tgt(tgt), .tgt_vld(tgt_vld)
);

// File: tb/test_tec_thermal_iir.sv
module test_tec_thermal_iir;
  logic clk = 0, rst = 1, smp_stb = 0, cfg_we = 0;
  logic signed [15:0] setpt = 0, therm = 0, cfg_data = 0;
  logic [3:0] cfg_addr = 0;
  logic signed [15:0] tgt;
  logic tgt_vld;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tec_thermal_iir i_tec_thermal_iir (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .setpt(setpt), .therm(therm),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .tgt(tgt), .tgt_vld(tgt_vld)
  );

  // independent model state
  longint mc [16];
  longint me [3];
  longint my [3];
  longint ms [2];
  longint mw [2];

  function automatic longint sat16(input longint a);
    if (a > 32767) return 32767;
    if (a < -32768) return -32768;
    return a;
  endfunction

  function automatic longint model(input longint s, input longint t);
    longint e, acc, ye, ys, v;
    e   = sat16(s - t);
    acc = mc[0]*e + mc[1]*me[0] + mc[2]*me[1] + mc[3]*me[2]
        - mc[4]*my[0] - mc[5]*my[1] - mc[6]*my[2];
    ye  = sat16(acc >>> 14);
    acc = mc[7]*s + mc[8]*ms[0] + mc[9]*ms[1] - mc[10]*mw[0] - mc[11]*mw[1];
    ys  = sat16(acc >>> 14);
    v   = sat16(ye + ys);
    me[2] = me[1]; me[1] = me[0]; me[0] = e;
    my[2] = my[1]; my[1] = my[0]; my[0] = ye;
    ms[1] = ms[0]; ms[0] = s;
    mw[1] = mw[0]; mw[0] = ys;
    return sat16(((v - 12288) * mc[12]) >>> 14);
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(negedge clk);
    @(negedge clk) rst = 0;
    for (int i = 0; i < 16; i++) mc[i] = 0;
    for (int i = 0; i < 3; i++) begin me[i] = 0; my[i] = 0; end
    for (int i = 0; i < 2; i++) begin ms[i] = 0; mw[i] = 0; end
  endtask

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_data = 16'(d);
    @(negedge clk) cfg_we = 0;
    if (a < 13) mc[a] = d;
  endtask

  task automatic run(input longint s, input longint t, output longint got, output longint exp, output int lat);
    @(negedge clk);
    smp_stb = 1; setpt = 16'(s); therm = 16'(t);
    exp = model(s, t);
    @(negedge clk) smp_stb = 0;
    lat = 0;
    got = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      lat++;
      if (tgt_vld) begin got = tgt; break; end
    end
  endtask

  localparam logic [31:0] STIM [8] = '{
    {16'sd3000, 16'sd1000}, {16'sd3000, 16'sd2500}, {-16'sd2000, 16'sd4000}, {16'sd12000, -16'sd9000},
    {16'sd500, 16'sd500}, {16'sd30000, -16'sd30000}, {-16'sd30000, 16'sd30000}, {16'sd7000, 16'sd6800}
  };

  initial begin
    #1200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint got, exp;
    int lat;
    do_reset();
    chk("R8 reset tgt", tgt, 0);
    chk("R8 reset vld", tgt_vld, 0);

    wr(0, 16384); wr(12, 16384);
    run(20000, 5000, got, exp, lat);
    chk("R1 R4 basic", got, 2712);
    chk("R6 latency", lat, 15);
    @(negedge clk) chk("R6 pulse width", tgt_vld, 0);
    run(32767, -32768, got, exp, lat);
    chk("R1 R5 error saturation", got, 20479);
    wr(12, 32767);
    run(32767, -32768, got, exp, lat);
    chk("R4 R5 R9 positive output saturation", got, 32767);
    run(-32768, 32767, got, exp, lat);
    chk("R5 negative output saturation", got, -32768);

    do_reset();
    wr(0, 16384); wr(4, -16384); wr(12, 16384);
    run(100, 0, got, exp, lat); chk("R2 integrator 1", got, -12188);
    run(100, 0, got, exp, lat); chk("R2 integrator 2", got, -12088);
    run(100, 0, got, exp, lat); chk("R2 integrator 3", got, -11988);
    do_reset();
    wr(0, 16384); wr(4, -16384); wr(12, 16384);
    run(100, 0, got, exp, lat); chk("R8 history cleared", got, -12188);

    do_reset();
    wr(7, 8192); wr(10, -8192); wr(12, 16384);
    run(1000, 1000, got, exp, lat); chk("R3 setpoint path 1", got, -11788);
    run(1000, 1000, got, exp, lat); chk("R3 setpoint path 2", got, -11538);

    // R7: strobe while busy
    do_reset();
    wr(0, 16384); wr(12, 16384);
    @(negedge clk);
    smp_stb = 1; setpt = 20000; therm = 5000;
    exp = model(20000, 5000);
    @(negedge clk) smp_stb = 0;
    lat = 0; got = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      lat++;
      if (lat == 4) begin setpt = 0; therm = 30000; end
      smp_stb = (lat == 5);
      if (tgt_vld) begin got = tgt; break; end
    end
    smp_stb = 0;
    chk("R7 result unaffected", got, 2712);
    chk("R7 latency unaffected", lat, 15);
    begin
      int extra = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (tgt_vld) extra++; end
      chk("R7 no extra result", extra, 0);
    end
    wr(0, 0); wr(1, 16384);
    run(5000, 5000, got, exp, lat);
    chk("R7 history untouched", got, 2712);

    // R9: unused addresses
    wr(13, 16384); wr(15, -16384);
    run(5000, 5000, got, exp, lat);
    chk("R9 unused address ignored", got, -12288);

    // table walk with mixed coefficients
    do_reset();
    wr(0, 6000); wr(1, -3000); wr(2, 1500); wr(3, -700);
    wr(4, -9000); wr(5, 3000); wr(6, -500);
    wr(7, 4000); wr(8, 2000); wr(9, -1000); wr(10, -6000); wr(11, 2000);
    wr(12, 12000);
    for (int v = 0; v < 8; v++) begin
      run(longint'($signed(STIM[v][31:16])), longint'($signed(STIM[v][15:0])), got, exp, lat);
      chk("R2 R3 R5 table", got, exp);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule